// File: doc/BRIEF.md
# Funnel Shifter with Four Shift Modes

This block is a purely combinational 32-bit shifter for an integer execution unit. Every shift and rotate reduces to one operation: a right extraction from a double-width word. The mode logic builds an upper fill word and a lower word, and picks an effective amount. A cascade of 2:1 multiplexer stages, one per bit of the amount, then slides the double-width word right and keeps the low 32 bits.

The control part decodes the mode and the requested amount into a small bundle of strobes. That bundle holds which upper fill to use, whether to clear the lower word, and the effective amount. The datapath part forms the funnel and runs the stages. The result follows the inputs within the same cycle, and no register lies on the path.

Top module: `funnel_shifter`

## Requirements
- R1: With shiftMode = 2'b00 (shift left logical) and amount s, result equals opndA shifted left by s, with s zeros entering at bit 0.
- R2: With shiftMode = 2'b01 (shift right logical) and amount s, result equals opndA shifted right by s, with s zeros entering at bit 31.
- R3: With shiftMode = 2'b10 (shift right arithmetic) and amount s, result equals opndA shifted right by s, with s copies of opndA[31] entering at the top.
- R4: With shiftMode = 2'b11 (rotate right) and amount s, the bits that leave bit 0 re-enter at bit 31, so result[j] = opndA[(j+s) mod 32].
- R5: An amount of 0 returns opndA unchanged in all four modes.
- R6: At the largest amount, 31: a left shift leaves only opndA[0], at bit 31. A logical right shift leaves only opndA[31], at bit 0. An arithmetic right shift gives 32 copies of opndA[31]. A rotate gives {opndA[30:0], opndA[31]}.
- R7: The result is a combinational function of the inputs. A change on the inputs is visible on result before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opndA | input | 32 | Data word to be shifted or rotated |
| shiftAmt | input | 5 | Requested shift distance, 0 to 31 |
| shiftMode | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| result | output | 32 | Shifted or rotated word |

## Verification
The hardest case to reach is a left shift by zero. The effective amount wraps to zero there, and the lower word must not be cleared. A wrong choice shows up only at that single amount, and only in that mode. The bench sweeps all 32 amounts in every mode over a mix of fixed and random words, so the amount-0 corner meets every mode. The fixed words include a lone sign bit, a lone low bit, all ones and alternating patterns. With these, a fill of the wrong kind shows as a wrong bit at the edge where bits enter.

// File: rtl/shift_pkg.sv
package shift_pkg;
  parameter int DATA_W = 32;
  localparam int AMT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    MODE_SLL = 2'b00,
    MODE_SRL = 2'b01,
    MODE_SRA = 2'b10,
    MODE_ROR = 2'b11
  } shift_mode_e;

  typedef enum logic [1:0] {
    UP_ZERO = 2'b00,
    UP_SIGN = 2'b01,
    UP_DATA = 2'b10
  } upper_sel_e;

  typedef struct packed {
    upper_sel_e       upperSel;
    logic             lowerZero;
    logic [AMT_W-1:0] amount;
  } shift_strobes_t;
endpackage

// File: rtl/funnel_ctrl.sv
module funnel_ctrl
  import shift_pkg::*;
(
  input  logic [1:0]       modeIn,
  input  logic [AMT_W-1:0] amtIn,
  output shift_strobes_t   strb
);
  shift_mode_e modeDec;
  logic        amtNonZero;

  assign modeDec    = shift_mode_e'(modeIn);
  assign amtNonZero = |amtIn;

  always_comb begin
    strb.upperSel  = UP_ZERO;
    strb.lowerZero = 1'b0;
    strb.amount    = amtIn;
    unique case (modeDec)
      MODE_SLL: begin
        strb.upperSel  = UP_DATA;
        strb.lowerZero = amtNonZero;
        strb.amount    = '0 - amtIn;
      end
      MODE_SRL: strb.upperSel = UP_ZERO;
      MODE_SRA: strb.upperSel = UP_SIGN;
      MODE_ROR: strb.upperSel = UP_DATA;
      default:  strb.upperSel = UP_ZERO;
    endcase
  end

  always_comb begin
    // R4
    ror_wraps_chk: assert (modeDec != MODE_ROR ||
                           (strb.upperSel == UP_DATA && !strb.lowerZero && strb.amount == amtIn));
    // R5
    zero_amt_keeps_lower_chk: assert (amtNonZero || (!strb.lowerZero && strb.amount == '0));
  end
endmodule

// File: rtl/funnel_dp.sv
module funnel_dp
  import shift_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  input  shift_strobes_t    strb,
  output logic [DATA_W-1:0] dataOut
);
  localparam int W  = DATA_W;
  localparam int AW = AMT_W;
  localparam int FUNNEL_W = 2 * W - 1;

  logic [W-2:0]      upperWord;
  logic [W-1:0]      lowerWord;
  logic [FUNNEL_W-1:0] funnelIn;

  always_comb begin
    unique case (strb.upperSel)
      UP_SIGN: upperWord = {(W-1){dataIn[W-1]}};
      UP_DATA: upperWord = dataIn[W-2:0];
      default: upperWord = '0;
    endcase
  end

  assign lowerWord = strb.lowerZero ? '0 : dataIn;
  assign funnelIn  = {upperWord, lowerWord};

  for (genvar j = 0; j < AW; j++) begin : stg
    localparam int K     = AW - 1 - j;
    localparam int DIST  = 1 << K;
    localparam int IN_W  = W + (1 << (K + 1)) - 1;
    localparam int OUT_W = W + (1 << K) - 1;
    logic [IN_W-1:0]  inVal;
    logic [OUT_W-1:0] outVal;
    if (j == 0) begin : g_first
      assign inVal = funnelIn;
    end else begin : g_next
      assign inVal = stg[j-1].outVal;
    end
    assign outVal = strb.amount[K] ? inVal[DIST +: OUT_W] : inVal[OUT_W-1:0];
  end

  assign dataOut = stg[AW-1].outVal;

  always_comb begin
    // R1
    sll_low_zero_chk: assert (!strb.lowerZero || dataOut[0] == 1'b0);
    // R2
    srl_top_zero_chk: assert (!(strb.upperSel == UP_ZERO && strb.amount != '0) ||
                              dataOut[W-1] == 1'b0);
    // R3
    sra_sign_fill_chk: assert (strb.upperSel != UP_SIGN || dataOut[W-1] == dataIn[W-1]);
  end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import shift_pkg::*;
(
  input  logic [DATA_W-1:0] opndA,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [1:0]        shiftMode,
  output logic [DATA_W-1:0] result
);
  shift_strobes_t strb;

  funnel_ctrl u_ctrl (
    .modeIn (shiftMode),
    .amtIn  (shiftAmt),
    .strb   (strb)
  );

  funnel_dp u_dp (
    .dataIn  (opndA),
    .strb    (strb),
    .dataOut (result)
  );

  always_comb begin
    // R5
    zero_shift_identity_chk: assert (shiftAmt != '0 || result == opndA);
  end
endmodule

// File: tb/sim_funnel_shifter.sv
module sim_funnel_shifter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opndA = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  shiftMode = '0;
  logic [31:0] result;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  funnel_shifter u0 (
    .opndA     (opndA),
    .shiftAmt  (shiftAmt),
    .shiftMode (shiftMode),
    .result    (result)
  );

  function automatic logic [31:0] refShift(input logic [1:0] m, input logic [31:0] a,
                                           input int s);
    case (m)
      2'b00:   return a << s;
      2'b01:   return a >> s;
      2'b10:   return 32'($signed(a) >>> s);
      default: return (s == 0) ? a : ((a >> s) | (a << (32 - s)));
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] expv);
    nChecks++;
    if (result !== expv) begin
      nFails++;
      $display("FAIL %s mode=%0d amt=%0d a=%h actual=%h expected=%h",
               tag, shiftMode, shiftAmt, opndA, result, expv);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] a, input int s);
    @(negedge clk);
    shiftMode = m;
    opndA     = a;
    shiftAmt  = 5'(s);
    #1;
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0000;
    pats[1] = 32'h0000_0001;
    pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'hA5A5_5A5A;
    pats[4] = 32'h7FFF_FFFF;
    pats[5] = 32'h0000_0000;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-state check: all inputs zero gives zero
    #1;
    check("R5", 32'h0);
    for (int d = 0; d < 14; d++) begin
      logic [31:0] a;
      a = (d < 6) ? pats[d] : $urandom;
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 32; s++) begin
          string tag;
          apply(2'(m), a, s);
          if (s == 0)       tag = "R5";
          else if (s == 31) tag = "R6";
          else if (m == 0)  tag = "R1";
          else if (m == 1)  tag = "R2";
          else if (m == 2)  tag = "R3";
          else              tag = "R4";
          check(tag, refShift(2'(m), a, s));
        end
      end
    end
    // R6 explicit boundary words
    apply(2'b00, 32'h0000_0001, 31); check("R6", 32'h8000_0000);
    apply(2'b01, 32'h8000_0000, 31); check("R6", 32'h0000_0001);
    apply(2'b10, 32'h8000_0000, 31); check("R6", 32'hFFFF_FFFF);
    apply(2'b11, 32'h8000_0001, 31); check("R6", 32'h0000_0003);
    // R7: change inputs mid-cycle, sample before next edge
    @(posedge clk);
    #1;
    opndA = 32'h1234_5678; shiftAmt = 5'd8; shiftMode = 2'b11;
    #1;
    check("R7", 32'h7812_3456);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (rstN);
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule